// File: doc/BRIEF.md
# Activity Monitor Configuration Read Permission Checker

This block settles the outcome of a software read of the read-only register that describes how many event counters each activity-monitor counter group holds. A request arrives with the system register encoding, the current privilege level (0 to 3), flags saying whether levels 2 and 3 exist and are enabled, the trap-control bits, the user-access enable bit and the secure-debug condition flags. One clock edge later the block returns a single response pulse with exactly one outcome: read data, undefined instruction, a trap routed to a level with its syndrome class, or "no match" when the encoding is not the one this block owns.

The checks form a fixed-priority chain whose shape depends on the privilege level. At levels 0 to 2, a secure-debug override is evaluated before anything else. Level 0 then consults the user-access enable, levels 0 and 1 consult the level-2 trap bit, and every level below 3 ends with the level-3 trap bit. Level 3 always reads. The read value carries a fixed architected count of four and an auxiliary count set at elaboration.

Top module: `amon_cfg_access`

## Requirements
- R1: A request matches only when op0=3, op1=3, CRn=13, CRm=2 and op2=2. Any other encoding gives a response with `rsp_nomatch`=1 and read, undefined and trap all 0.
- R2: On a matching request with `mon_impl`=0, the outcome is undefined at every level.
- R3: At levels 0, 1 and 2, when `lvl3_exists`, `sdd_prio` and `lvl3_tam` are all 1, the outcome is undefined, whatever the other inputs are.
- R4: At level 0, failing R3, `user_en`=0 traps: the target is level 2 when `lvl2_enabled` and `lvl2_tge` are both 1, and level 1 otherwise.
- R5: At levels 0 and 1, when the earlier checks pass, `lvl2_enabled`=1 with `lvl2_tam`=1 traps to level 2.
- R6: At levels 0 to 2, when the earlier checks pass, `lvl3_exists`=1 with `lvl3_tam`=1 gives undefined if `sdd_undef`=1 and a trap to level 3 otherwise. When none of the checks fires, the outcome is a read.
- R7: Level 2 ignores `user_en`, `lvl2_tam` and `lvl2_tge`. Level 3 always reads when the encoding matches and `mon_impl`=1.
- R8: A trap sets `rsp_class`=0x18 and `rsp_target` to the level number (1, 2 or 3). Read and undefined outcomes give `rsp_class`=0 and `rsp_target`=0.
- R9: On a read, `rsp_data`[7:0]=0x04, `rsp_data`[15:8]=AUX_COUNT and `rsp_data`[63:16]=0. All other outcomes give `rsp_data`=0.
- R10: A request with `req_valid`=1 gives one response with `rsp_valid`=1 at the next clock edge, with exactly one of read, undefined, trap and nomatch set. Without a request, and in reset, all response outputs are 0.
- R11: AUX_COUNT is limited to 0..16. A value outside that range stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_level | input | 2 | Current privilege level 0..3 |
| mon_impl | input | 1 | Activity-monitor feature present |
| lvl2_enabled | input | 1 | Level 2 is enabled |
| lvl3_exists | input | 1 | Level 3 exists |
| sdd_prio | input | 1 | Secure-debug undefined takes priority |
| sdd_undef | input | 1 | Secure-debug undefined condition |
| user_en | input | 1 | Level-0 user access enable |
| lvl2_tge | input | 1 | Level-2 route-general-exceptions bit |
| lvl2_tam | input | 1 | Level-2 monitor trap bit |
| lvl3_tam | input | 1 | Level-3 monitor trap bit |
| rsp_valid | output | 1 | Response pulse |
| rsp_read | output | 1 | Outcome: read completed |
| rsp_undef | output | 1 | Outcome: undefined instruction |
| rsp_trap | output | 1 | Outcome: trap |
| rsp_nomatch | output | 1 | Outcome: encoding not owned |
| rsp_target | output | 2 | Trap target level |
| rsp_class | output | 6 | Trap syndrome class |
| rsp_data | output | 64 | Read data |

## Verification
Several checks in the chain can be true in the same cycle, and the interesting collisions are between the secure-debug override and the user-access trap at level 0, and between the level-2 and level-3 trap bits at level 1. The vector table sets both conditions at once in these cases and expects the earlier check in the chain to win, for example undefined over a level-1 trap and a level-2 trap over a level-3 trap. Level 3 is driven with every trap bit set to show that all of them are bypassed.

// File: rtl/amon_cfg_access.sv
module amon_cfg_access #(
  parameter int AUX_COUNT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op0,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [1:0]  cur_level,
  input  logic        mon_impl,
  input  logic        lvl2_enabled,
  input  logic        lvl3_exists,
  input  logic        sdd_prio,
  input  logic        sdd_undef,
  input  logic        user_en,
  input  logic        lvl2_tge,
  input  logic        lvl2_tam,
  input  logic        lvl3_tam,
  output logic        rsp_valid,
  output logic        rsp_read,
  output logic        rsp_undef,
  output logic        rsp_trap,
  output logic        rsp_nomatch,
  output logic [1:0]  rsp_target,
  output logic [5:0]  rsp_class,
  output logic [63:0] rsp_data
);

  localparam int        MAX_AUX    = 16;
  localparam logic [7:0] ARCH_COUNT = 8'h04;
  localparam logic [5:0] TRAP_CLASS = 6'h18;
  localparam logic [7:0] AUX_FIELD  = 8'(AUX_COUNT);
  localparam logic [63:0] READ_VALUE = {48'd0, AUX_FIELD, ARCH_COUNT};

  if (AUX_COUNT < 0 || AUX_COUNT > MAX_AUX) begin : g_aux_range
    $error("AUX_COUNT must lie in 0..16");
  end

  logic       hit;
  logic       sdd_first;
  logic       k_read, k_undef, k_trap;
  logic [1:0] k_tgt;

  assign hit = (req_op0 == 2'd3) && (req_op1 == 3'd3) && (req_crn == 4'd13) &&
               (req_crm == 4'd2) && (req_op2 == 3'd2);

  assign sdd_first = lvl3_exists && sdd_prio && lvl3_tam;

  always_comb begin
    k_read  = 1'b0;
    k_undef = 1'b0;
    k_trap  = 1'b0;
    k_tgt   = 2'd0;
    if (hit) begin
      if (!mon_impl) begin
        k_undef = 1'b1;
      end else if (cur_level == 2'd3) begin
        k_read = 1'b1;
      end else if (sdd_first) begin
        k_undef = 1'b1;
      end else if (cur_level == 2'd0 && !user_en) begin
        k_trap = 1'b1;
        k_tgt  = (lvl2_enabled && lvl2_tge) ? 2'd2 : 2'd1;
      end else if (cur_level != 2'd2 && lvl2_enabled && lvl2_tam) begin
        k_trap = 1'b1;
        k_tgt  = 2'd2;
      end else if (lvl3_exists && lvl3_tam) begin
        if (sdd_undef) begin
          k_undef = 1'b1;
        end else begin
          k_trap = 1'b1;
          k_tgt  = 2'd3;
        end
      end else begin
        k_read = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_read    <= 1'b0;
      rsp_undef   <= 1'b0;
      rsp_trap    <= 1'b0;
      rsp_nomatch <= 1'b0;
      rsp_target  <= 2'd0;
      rsp_class   <= 6'd0;
      rsp_data    <= 64'd0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_read    <= req_valid && k_read;
      rsp_undef   <= req_valid && k_undef;
      rsp_trap    <= req_valid && k_trap;
      rsp_nomatch <= req_valid && !hit;
      rsp_target  <= (req_valid && k_trap) ? k_tgt : 2'd0;
      rsp_class   <= (req_valid && k_trap) ? TRAP_CLASS : 6'd0;
      rsp_data    <= (req_valid && k_read) ? READ_VALUE : 64'd0;
    end
  end

endmodule

// File: rtl/amon_cfg_access_chk.sv
module amon_cfg_access_chk #(
  parameter int AUX_COUNT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_op0,
  input logic [2:0]  req_op1,
  input logic [3:0]  req_crn,
  input logic [3:0]  req_crm,
  input logic [2:0]  req_op2,
  input logic [1:0]  cur_level,
  input logic        mon_impl,
  input logic        lvl2_enabled,
  input logic        lvl3_exists,
  input logic        sdd_prio,
  input logic        lvl2_tam,
  input logic        lvl3_tam,
  input logic        rsp_valid,
  input logic        rsp_read,
  input logic        rsp_undef,
  input logic        rsp_trap,
  input logic        rsp_nomatch,
  input logic [1:0]  rsp_target,
  input logic [5:0]  rsp_class,
  input logic [63:0] rsp_data
);

  logic own;
  assign own = req_op0 == 2'd3 && req_op1 == 3'd3 && req_crn == 4'd13 &&
               req_crm == 4'd2 && req_op2 == 3'd2;

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_read, rsp_undef, rsp_trap, rsp_nomatch}));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_read, rsp_undef, rsp_trap, rsp_nomatch} == 4'd0));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_nomatch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !own) |=> rsp_nomatch);

  assert_unimpl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && own && !mon_impl) |=> rsp_undef);

  assert_l2trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && own && mon_impl && cur_level == 2'd1 && lvl2_enabled && lvl2_tam &&
     !(lvl3_exists && sdd_prio && lvl3_tam)) |=> (rsp_trap && rsp_target == 2'd2));

  assert_top_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && own && mon_impl && cur_level == 2'd3) |=> rsp_read);

  assert_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_class == 6'h18 && rsp_target != 2'd0));

  assert_noclass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_trap |-> (rsp_class == 6'd0 && rsp_target == 2'd0));

  assert_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_read |-> (rsp_data[7:0] == 8'h04 && rsp_data[15:8] == 8'(AUX_COUNT) &&
                  rsp_data[63:16] == 48'd0));

  assert_nodata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_read |-> rsp_data == 64'd0);

endmodule

bind amon_cfg_access amon_cfg_access_chk #(.AUX_COUNT(AUX_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
  .req_op2(req_op2), .cur_level(cur_level), .mon_impl(mon_impl),
  .lvl2_enabled(lvl2_enabled), .lvl3_exists(lvl3_exists), .sdd_prio(sdd_prio),
  .lvl2_tam(lvl2_tam), .lvl3_tam(lvl3_tam), .rsp_valid(rsp_valid),
  .rsp_read(rsp_read), .rsp_undef(rsp_undef), .rsp_trap(rsp_trap),
  .rsp_nomatch(rsp_nomatch), .rsp_target(rsp_target), .rsp_class(rsp_class),
  .rsp_data(rsp_data)
);

// File: tb/tb_amon_cfg_access.sv
module tb_amon_cfg_access;
  localparam int AUX = 11;
  localparam int NV  = 21;
  // {lvl[15:14], impl, l3, l2en, prio, sdd, uen, tge, tam2, tam3, match, out[3:2], tgt[1:0]}
  // out: 0 read, 1 undef, 2 trap, 3 nomatch
  localparam logic [15:0] VEC [NV] = '{
    16'b00_1_0_0_0_0_1_0_0_0_1_00_00,  // R6 plain read
    16'b00_1_0_0_0_0_0_0_0_0_1_10_01,  // R4 to 1
    16'b00_1_0_1_0_0_0_1_0_0_1_10_10,  // R4 to 2
    16'b00_1_0_1_0_0_0_0_0_0_1_10_01,  // R4 tge clear
    16'b00_1_0_1_0_0_1_0_1_0_1_10_10,  // R5
    16'b00_1_0_0_0_0_1_0_1_0_1_00_00,  // R5 lvl2 disabled
    16'b00_1_1_0_0_0_1_0_0_1_1_10_11,  // R6 trap 3
    16'b00_1_1_0_0_1_1_0_0_1_1_01_00,  // R6 undef
    16'b00_1_1_0_1_0_0_0_0_1_1_01_00,  // R3 beats R4
    16'b01_1_0_0_0_0_0_0_0_0_1_00_00,  // R4 not at level 1
    16'b01_1_0_1_0_0_1_0_1_0_1_10_10,  // R5 level 1
    16'b01_1_1_1_0_0_1_0_1_1_1_10_10,  // R5 beats R6
    16'b10_1_0_1_0_0_0_0_1_0_1_00_00,  // R7 level 2 ignores
    16'b10_1_1_0_0_0_1_0_0_1_1_10_11,  // R6 level 2
    16'b10_1_1_0_1_0_1_0_0_1_1_01_00,  // R3 level 2
    16'b11_1_1_1_1_1_0_1_1_1_1_00_00,  // R7 level 3
    16'b11_0_0_0_0_0_1_0_0_0_1_01_00,  // R2
    16'b00_1_0_0_0_0_1_0_0_0_0_11_00,  // R1
    16'b00_0_0_0_0_0_1_0_0_0_0_11_00,  // R1 unimpl
    16'b01_1_0_0_1_0_1_0_0_1_1_00_00,  // R3 no level 3
    16'b00_1_1_0_0_0_0_0_0_1_1_10_01   // R4 beats R6
  };

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [1:0] req_op0 = 2'd3; logic [2:0] req_op1 = 3'd3;
  logic [3:0] req_crn = 4'd13, req_crm = 4'd2; logic [2:0] req_op2 = 3'd2;
  logic [1:0] cur_level = 2'd0;
  logic mon_impl = 1'b1, lvl2_enabled = 1'b0, lvl3_exists = 1'b0, sdd_prio = 1'b0;
  logic sdd_undef = 1'b0, user_en = 1'b1, lvl2_tge = 1'b0, lvl2_tam = 1'b0, lvl3_tam = 1'b0;
  logic rsp_valid, rsp_read, rsp_undef, rsp_trap, rsp_nomatch;
  logic [1:0] rsp_target; logic [5:0] rsp_class; logic [63:0] rsp_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  amon_cfg_access #(.AUX_COUNT(AUX)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [15:0] v);
    @(negedge clk);
    cur_level = v[15:14]; mon_impl = v[13]; lvl3_exists = v[12]; lvl2_enabled = v[11];
    sdd_prio = v[10]; sdd_undef = v[9]; user_en = v[8]; lvl2_tge = v[7];
    lvl2_tam = v[6]; lvl3_tam = v[5];
    req_op2 = v[4] ? 3'd2 : 3'd3;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [4:0] flags(input logic [1:0] o);
    return {1'b1, o == 2'd0, o == 2'd1, o == 2'd2, o == 2'd3};
  endfunction

  task automatic judge(input string req, input logic [1:0] o, input logic [1:0] t);
    chk({req, " outcome"}, 64'({rsp_valid, rsp_read, rsp_undef, rsp_trap, rsp_nomatch}),
        64'(flags(o)));
    chk({req, " target"}, 64'(rsp_target), 64'(t));
    chk({req, " class R8"}, 64'(rsp_class), (o == 2'd2) ? 64'h18 : 64'd0);
    chk({req, " data R9"}, rsp_data, (o == 2'd0) ? 64'h0B04 : 64'd0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R10 reset valid", 64'(rsp_valid), 64'd0);
    chk("R10 reset data", rsp_data, 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      fire(VEC[i]);
      judge($sformatf("R3-chain vector %0d", i), VEC[i][3:2], VEC[i][1:0]);
      @(negedge clk);
      chk("R10 single pulse", 64'(rsp_valid), 64'd0);
    end

    for (int f = 0; f < 5; f++) begin
      fire(16'b11_1_0_0_0_0_1_0_0_0_1_00_00);
      @(negedge clk);
      cur_level = 2'd3; mon_impl = 1'b1;
      req_op0 = (f == 0) ? 2'd2 : 2'd3; req_op1 = (f == 1) ? 3'd0 : 3'd3;
      req_crn = (f == 2) ? 4'd12 : 4'd13; req_crm = (f == 3) ? 4'd3 : 4'd2;
      req_op2 = (f == 4) ? 3'd1 : 3'd2;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      judge("R1 field mismatch", 2'd3, 2'd0);
      req_op0 = 2'd3; req_op1 = 3'd3; req_crn = 4'd13; req_crm = 4'd2; req_op2 = 3'd2;
    end

    @(negedge clk);
    cur_level = 2'd0; mon_impl = 1'b1; lvl3_exists = 1'b0; lvl2_enabled = 1'b0;
    user_en = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    judge("R10 back-to-back first", 2'd0, 2'd0);
    user_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    judge("R10 back-to-back second R4", 2'd2, 2'd1);
    @(negedge clk);
    chk("R10 idle after burst", 64'(rsp_valid), 64'd0);
    chk("R11 aux field", 64'(rsp_data[15:8]), 64'd0);

    @(negedge clk) user_en = 1'b1; req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
    chk("R11 aux count in data", 64'(rsp_data[15:8]), 64'(AUX));
    chk("R9 upper zero", rsp_data >> 16, 64'd0);

    @(negedge clk) req_valid = 1'b1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears", 64'({rsp_valid, rsp_read, rsp_data != 0}), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule